// File: doc/BRIEF.md
# Countdown Timer with Register Interface

A single-channel down-counting timer that a processor controls through four word-wide registers on a plain read/write strobe bus. Software loads a reload value, then starts or stops the count with strobe bits in the control word. When the count runs out the block raises a sticky timeout flag. The count either reloads and keeps going, or it halts. A level interrupt follows that flag, masked by an enable bit.

Registers sit at byte offsets 0x0 (status), 0x4 (control), 0x8 (period) and 0xC (snapshot). Byte address bits [3:2] select the word. All accesses are full words. A read request returns its data on `rsp_data` one cycle later, marked by `rsp_valid`. Expiry is the clock edge on which a running count would reach zero. A period of N therefore gives a timeout every N cycles in continuous mode.

Top module: `countdown_timer`

## Requirements
- R1: After reset all four registers read 0, the counter is stopped and `irq` is low.
- R2: A period write stores the value and loads it into the counter on the same edge. A later read of the period or the snapshot word returns it.
- R3: Control bit 2 (start) sets the count running, and status bit 1 then reads 1. While running, the counter drops by one on each clock.
- R4: In one-shot mode (control bit 1 clear), expiry sets status bit 0, clears status bit 1 and leaves the counter at 0.
- R5: In continuous mode (control bit 1 set), expiry sets status bit 0 and reloads the counter from the period, so the counter keeps running and expires every period cycles.
- R6: Control bit 3 (stop) halts the count on the edge it is written, and the counter then holds its value. When start and stop are written together, stop wins.
- R7: Any write to the status word clears the timeout flag, whatever the data. If an expiry falls on the same edge, the flag stays set.
- R8: `irq` is high exactly while the timeout flag and control bit 0 (interrupt enable) are both set. Clearing the enable does not clear the flag.
- R9: Writes to the snapshot word change neither the counter nor any other register.
- R10: Every read request yields exactly one `rsp_valid` pulse with the data, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_wr | input | 1 | Write strobe |
| req_rd | input | 1 | Read strobe |
| req_addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| req_data | input | DATA_W | Write data |
| rsp_data | output | DATA_W | Read data |
| rsp_valid | output | 1 | Read data valid, one cycle after `req_rd` |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with a 16-bit data path and a 4-bit address. This keeps the counter small, so the one-shot and continuous expiries fall within a few cycles of the start. It also shows that register bit positions do not depend on the width. A period of 4 in continuous mode places an expiry on the same edge as a status write, which exercises the corner of R7 where the set takes priority. Stopping the count at a chosen edge makes the expected snapshot value exact for the decrement rate.

// File: rtl/countdown_timer.sv
module countdown_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_valid,
  output logic              irq
);
  localparam logic [1:0] W_STAT = 2'd0;
  localparam logic [1:0] W_CTRL = 2'd1;
  localparam logic [1:0] W_PER  = 2'd2;
  localparam logic [1:0] W_SNAP = 2'd3;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] ctrl_q, per_q, cnt_q;
  logic run_q, to_q;

  wire [1:0] widx    = req_addr[3:2];
  wire wr_stat       = req_wr && widx == W_STAT;
  wire wr_ctrl       = req_wr && widx == W_CTRL;
  wire wr_per        = req_wr && widx == W_PER;
  wire do_stop       = wr_ctrl && req_data[3];
  wire do_start      = wr_ctrl && req_data[2] && !req_data[3];
  wire cont          = ctrl_q[1];
  wire expire        = run_q && !do_stop && !wr_per && cnt_q <= ONE;

  assign irq = to_q & ctrl_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= req_data;
      if (wr_per)  per_q  <= req_data;

      if (wr_per)                   cnt_q <= req_data;
      else if (expire)              cnt_q <= cont ? per_q : '0;
      else if (run_q && !do_stop)   cnt_q <= cnt_q - ONE;

      if (do_stop)       run_q <= 1'b0;
      else if (do_start) run_q <= 1'b1;
      else if (expire)   run_q <= cont;

      if (expire)       to_q <= 1'b1;
      else if (wr_stat) to_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= req_rd;
      if (req_rd) begin
        case (widx)
          W_STAT:  rsp_data <= {{(DATA_W-2){1'b0}}, run_q, to_q};
          W_CTRL:  rsp_data <= ctrl_q;
          W_PER:   rsp_data <= per_q;
          default: rsp_data <= cnt_q;
        endcase
      end
    end
  end

  p_period_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_per |=> cnt_q == $past(req_data));

  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q > ONE && !req_wr) |=> (run_q && cnt_q == $past(cnt_q) - ONE));

  p_oneshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q <= ONE && !ctrl_q[1] && !req_wr) |=> (!run_q && to_q && cnt_q == '0));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q <= ONE && ctrl_q[1] && !req_wr) |=> (run_q && to_q && cnt_q == per_q));

  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && widx == W_CTRL && req_data[3]) |=> !run_q);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(req_wr && widx == W_PER)) |=> $stable(cnt_q));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && widx == W_STAT && !(run_q && cnt_q <= ONE)) |=> !to_q);

  p_read_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> rsp_valid);
endmodule

// File: tb/countdown_timer_test.sv
module countdown_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_STAT = 4'h0, A_CTRL = 4'h4, A_PER = 4'h8, A_SNAP = 4'hC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid, irq;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  countdown_timer #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_wr(wr), .req_rd(rd), .req_addr(addr),
    .req_data(wdata), .rsp_data(rdata), .rsp_valid(rvalid), .irq(irq));

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk); rd = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected response actual=%h expected=none", rdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s read actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_irq(1'b0, "R1");
    rd_reg(A_STAT, 16'h0, "R1 status");
    rd_reg(A_CTRL, 16'h0, "R1 control");
    rd_reg(A_PER,  16'h0, "R1 period");
    rd_reg(A_SNAP, 16'h0, "R1 snapshot");

    wr_reg(A_PER, 16'h1234);
    rd_reg(A_SNAP, 16'h1234, "R2 snapshot after period write");
    rd_reg(A_PER,  16'h1234, "R2 period");

    wr_reg(A_PER, 16'd100);
    wr_reg(A_CTRL, 16'h4);
    rd_reg(A_STAT, 16'h2, "R3 running bit");
    idle(3);
    wr_reg(A_CTRL, 16'h8);
    rd_reg(A_SNAP, 16'd94, "R3 one per clock, R6 stop");
    rd_reg(A_STAT, 16'h0, "R6 stopped");
    wr_reg(A_CTRL, 16'hC);
    rd_reg(A_STAT, 16'h0, "R6 stop wins over start");
    rd_reg(A_SNAP, 16'd94, "R6 count held");

    wr_reg(A_PER, 16'd5);
    wr_reg(A_CTRL, 16'h5);
    idle(8);
    check_irq(1'b1, "R8 flag and enable");
    rd_reg(A_STAT, 16'h1, "R4 one-shot flag set, stopped");
    rd_reg(A_SNAP, 16'h0, "R4 counter at zero");
    wr_reg(A_CTRL, 16'h0);
    check_irq(1'b0, "R8 enable cleared");
    rd_reg(A_STAT, 16'h1, "R8 flag kept");
    wr_reg(A_CTRL, 16'h1);
    check_irq(1'b1, "R8 enable set again");
    wr_reg(A_STAT, 16'h0);
    check_irq(1'b0, "R7 cleared by zero data");
    rd_reg(A_STAT, 16'h0, "R7 flag cleared");

    wr_reg(A_PER, 16'd4);
    wr_reg(A_CTRL, 16'h6);
    rd_reg(A_STAT, 16'h2, "R5 running before expiry");
    rd_reg(A_STAT, 16'h2, "R5 before first expiry");
    rd_reg(A_STAT, 16'h3, "R5 expired and still running");
    wr_reg(A_STAT, 16'hFFFF);
    rd_reg(A_STAT, 16'h3, "R7 expiry beats clear");
    idle(1);
    wr_reg(A_STAT, 16'h005A);
    rd_reg(A_STAT, 16'h2, "R7 clear between expiries");
    rd_reg(A_SNAP, 16'd4, "R5 reloaded from period");
    wr_reg(A_CTRL, 16'h8);
    wr_reg(A_SNAP, 16'h0077);
    rd_reg(A_SNAP, 16'd2, "R9 snapshot write ignored");
    rd_reg(A_PER, 16'd4, "R9 period untouched");
    rd_reg(A_CTRL, 16'h8, "R9 control untouched");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 responses missing actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule